// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock of an I2C controller from a fast source clock. A prescaler divides the source clock into ticks. Three programmable tick counts shape each SCL period: a low time, a high time and a whole-cycle length. When the cycle count is larger than high plus low, the spare ticks are spent with the line released but before the high time starts counting. That spare time acts as a rise-time allowance.

A command engine enables the block and starts or stops clocking. The bit-level sequencer takes two strobes from it. One falls in the middle of each low phase, where SDA may change. The other falls in the middle of each counted high phase, where SDA is sampled. The SCL output is open drain. The block observes the real line level, so a target that holds SCL low stretches the high phase instead of shortening it.

Top module: `scl_timing_gen`

## Requirements
- R1: `tick` pulses once every D source cycles while clocking, with D taken from `div_in` (a value of 0 behaves as 1).
- R2: Each period begins with `scl_drive_low`=1 (pull SCL low) for L·D source cycles, where L is `cfg_word[19:10]` (0 behaves as 1).
- R3: After the low phase and any spare ticks, SCL is released and the high phase counts H ticks, where H is `cfg_word[29:20]` (0 behaves as 1).
- R4: With C = `cfg_word[9:0]`, if C > H+L then C−H−L released ticks come before the counted high phase, and the period lasts C·D cycles. Otherwise the period lasts (H+L)·D cycles.
- R5: While SCL is released in the high phase but `scl_in` reads low, the high count and the prescaler pause, so a stretched low adds exactly its extra cycles to the low time on the line.
- R6: `mid_low_stb` pulses once per low phase, on the tick that ends low tick number floor(L/2), counting from 0.
- R7: `mid_high_stb` pulses once per high phase, on the tick that ends counted high tick number floor(H/2), counting from 0.
- R8: With `enable`=0, SCL is released from the next cycle, no tick or strobe is produced, and all counters return to zero. A later enable starts with a full low phase.
- R9: Clocking starts in the cycle after `enable` and `run` are both seen high. Dropping `run` lets the current period finish its high phase, after which SCL stays released.
- R10: `cfg_word` and `div_in` are captured only when a period starts. A change during a period shapes the next period onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Serial-clock enable; low forces idle |
| run | input | 1 | Start (1) / stop (0) clocking from the command engine |
| div_in | input | DIV_W | Source cycles per tick |
| cfg_word | input | 30 | High count [29:20], low count [19:10], cycle count [9:0] |
| scl_in | input | 1 | Observed SCL line level (already synchronized) |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| tick | output | 1 | Prescaler strobe |
| mid_low_stb | output | 1 | Middle of low phase, for SDA updates |
| mid_high_stb | output | 1 | Middle of counted high phase, for SDA sampling |

## Verification
The three standard speed presets are run so that divider values of 7, 2 and 1, each with spare ticks, are distinguished by measured low and high run lengths on the modelled open-drain line. A setting whose cycle count is below high plus low shows that the period falls back to the sum. An all-zero setting exercises the clamping of every field. A stretched run with no spare ticks separates a paused high count from a free-running one. A configuration change in mid-period shows whether capture happens at the period boundary. A disable in mid-low, followed by a re-enable, shows that the counters restart from zero.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    localparam int CNT_W = 10;
    localparam int CFG_W = 3 * CNT_W;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_RISE,
        PH_HIGH
    } scl_phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] high_n;
        logic [CNT_W-1:0] low_n;
        logic [CNT_W-1:0] extra_n;
    } scl_cfg_t;

    function automatic scl_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        scl_cfg_t         r;
        logic [CNT_W-1:0] h;
        logic [CNT_W-1:0] l;
        logic [CNT_W:0]   c;
        logic [CNT_W:0]   sum;
        h   = w[3*CNT_W-1:2*CNT_W];
        l   = w[2*CNT_W-1:CNT_W];
        c   = {1'b0, w[CNT_W-1:0]};
        if (h == '0) h = CNT_W'(1);
        if (l == '0) l = CNT_W'(1);
        sum = {1'b0, h} + {1'b0, l};
        r.high_n  = h;
        r.low_n   = l;
        r.extra_n = (c > sum) ? CNT_W'(c - sum) : '0;
        return r;
    endfunction

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             hold,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_m1;

    assign div_m1 = (div_val == '0) ? '0 : div_val - 1'b1;
    assign tick   = !clear && !hold && (cnt == div_m1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (!hold) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

    // R5: a held prescaler keeps its count
    p_hold_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (hold && !clear) |=> (cnt == $past(cnt)));

    // R1: with a divider above one, ticks never come back to back
    p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && div_m1 != '0) |=> (!tick || div_m1 == '0));

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_timing_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             run,
    input  logic             scl_in,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [DIV_W-1:0] div_in,
    input  logic             tick,
    output logic             pre_clear,
    output logic             pre_hold,
    output logic [DIV_W-1:0] div_cur,
    output logic             drive_low,
    output logic             mid_low_stb,
    output logic             mid_high_stb
);
    scl_phase_e       st;
    logic [CNT_W-1:0] ph;
    logic [CNT_W-1:0] ph_len;
    logic             ph_last;
    scl_cfg_t         cfg_l;
    logic [DIV_W-1:0] div_l;

    always_comb begin
        unique case (st)
            PH_LOW:  ph_len = cfg_l.low_n;
            PH_RISE: ph_len = cfg_l.extra_n;
            PH_HIGH: ph_len = cfg_l.high_n;
            default: ph_len = CNT_W'(1);
        endcase
    end

    assign ph_last      = (ph == ph_len - 1'b1);
    assign pre_clear    = (st == PH_IDLE);
    assign pre_hold     = (st == PH_HIGH) && !scl_in;
    assign div_cur      = div_l;
    assign drive_low    = (st == PH_LOW);
    assign mid_low_stb  = tick && (st == PH_LOW)  && (ph == (cfg_l.low_n  >> 1));
    assign mid_high_stb = tick && (st == PH_HIGH) && (ph == (cfg_l.high_n >> 1));

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            st    <= PH_IDLE;
            ph    <= '0;
            cfg_l <= '0;
            div_l <= '0;
        end else if (st == PH_IDLE) begin
            if (run) begin
                cfg_l <= decode_cfg(cfg_word);
                div_l <= div_in;
                st    <= PH_LOW;
                ph    <= '0;
            end
        end else if (tick) begin
            if (!ph_last) begin
                ph <= ph + 1'b1;
            end else begin
                ph <= '0;
                unique case (st)
                    PH_LOW:  st <= (cfg_l.extra_n != '0) ? PH_RISE : PH_HIGH;
                    PH_RISE: st <= PH_HIGH;
                    default: begin
                        if (run) begin
                            cfg_l <= decode_cfg(cfg_word);
                            div_l <= div_in;
                            st    <= PH_LOW;
                        end else begin
                            st <= PH_IDLE;
                        end
                    end
                endcase
            end
        end
    end

    // R10: settings stay fixed inside a running period
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (st != PH_IDLE && ph != '0) |-> ($stable(cfg_l) && $stable(div_l)));

    // R5: a line held low freezes the high phase
    p_stretch_pause_r5: assert property (@(posedge clk) disable iff (rst)
        (st == PH_HIGH && !scl_in && enable) |=> ($stable(ph) && st == PH_HIGH));

    // R2: the low phase never runs past its count
    p_low_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (st == PH_LOW) |-> (ph < cfg_l.low_n));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             tick,
    output logic             mid_low_stb,
    output logic             mid_high_stb
);
    logic             pre_clear;
    logic             pre_hold;
    logic [DIV_W-1:0] div_cur;

    scl_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clear   (pre_clear),
        .hold    (pre_hold),
        .div_val (div_cur),
        .tick    (tick)
    );

    scl_phase_seq #(.DIV_W(DIV_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .run          (run),
        .scl_in       (scl_in),
        .cfg_word     (cfg_word),
        .div_in       (div_in),
        .tick         (tick),
        .pre_clear    (pre_clear),
        .pre_hold     (pre_hold),
        .div_cur      (div_cur),
        .drive_low    (scl_drive_low),
        .mid_low_stb  (mid_low_stb),
        .mid_high_stb (mid_high_stb)
    );

    // R8: disabling releases the line and silences ticks next cycle
    p_idle_release_r8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!scl_drive_low && !tick && !mid_low_stb));

    // R6: strobes are exclusive and the mid-low one only while pulling low
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        mid_low_stb |-> (scl_drive_low && !mid_high_stb));

endmodule

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;
    import scl_timing_pkg::*;

    typedef struct {
        bit    lvl;
        int    len;
        int    mid;
        bit    open;
        string tag;
    } run_item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b0;
    logic             run = 1'b0;
    logic [7:0]       div_in = '0;
    logic [CFG_W-1:0] cfg_word = '0;
    logic             scl_drive_low, tick, mid_low_stb, mid_high_stb;
    logic             hold = 1'b0;
    logic             scl_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    bit armed    = 0;
    int stretch_s = 0;
    int hcnt = 0;
    run_item_t q[$];

    always #4 clk = ~clk;

    assign scl_line = ~(scl_drive_low | hold);

    scl_timing_gen #(.DIV_W(8)) dut_i (
        .clk(clk), .rst(rst), .enable(enable), .run(run), .div_in(div_in),
        .cfg_word(cfg_word), .scl_in(scl_line), .scl_drive_low(scl_drive_low),
        .tick(tick), .mid_low_stb(mid_low_stb), .mid_high_stb(mid_high_stb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // target model: holds the line low for stretch_s cycles after release
    always begin
        @(posedge clk);
        #1;
        if (stretch_s > 0 && scl_drive_low) begin
            hcnt = stretch_s;
            hold = 1'b1;
        end else if (hcnt > 0) begin
            hold = 1'b1;
            hcnt--;
        end else begin
            hold = 1'b0;
        end
    end

    // monitor: measures line run lengths and strobe positions
    bit prev_lvl = 1'b1;
    bit track = 0;
    int run_len = 0;
    int seen = 0;
    always @(negedge clk) begin
        if (!armed) track = 0;
        if (scl_line != prev_lvl) begin
            if (track) begin
                if (q.size() == 0) begin
                    chk(0, "R2/R3 unexpected run", run_len, 0);
                end else begin
                    run_item_t it;
                    it = q.pop_front();
                    chk(it.lvl == prev_lvl, {it.tag, " level"}, prev_lvl, it.lvl);
                    chk(it.len == run_len, {it.tag, " length"}, run_len, it.len);
                    chk(seen == 1, it.lvl ? "R7 strobe count" : "R6 strobe count", seen, 1);
                end
            end
            track   = armed;
            run_len = 1;
            seen    = 0;
        end else begin
            run_len++;
        end
        prev_lvl = scl_line;
        if (track && (mid_low_stb || mid_high_stb) && q.size() > 0) begin
            chk(q[0].lvl == mid_high_stb, mid_high_stb ? "R7 strobe phase" : "R6 strobe phase",
                mid_high_stb, q[0].lvl);
            chk(q[0].mid == run_len, mid_high_stb ? "R7 strobe position" : "R6 strobe position",
                run_len, q[0].mid);
            seen++;
        end
    end

    function automatic logic [CFG_W-1:0] pack(input int h, input int l, input int c);
        return {10'(h), 10'(l), 10'(c)};
    endfunction

    task automatic push_period(input int dv, input int h, input int l, input int c,
                               input int s, input bit last);
        run_item_t lo, hi;
        int d, hh, ll, ex;
        d  = (dv == 0) ? 1 : dv;
        hh = (h == 0) ? 1 : h;
        ll = (l == 0) ? 1 : l;
        ex = (c > hh + ll) ? c - hh - ll : 0;
        lo.lvl = 0; lo.len = ll * d + s; lo.mid = (ll / 2 + 1) * d; lo.open = 0;
        lo.tag = (s > 0) ? "R5 stretched low" : "R2 low";
        hi.lvl = 1; hi.len = (ex + hh) * d; hi.mid = (ex + hh / 2 + 1) * d; hi.open = last;
        hi.tag = (ex > 0) ? "R4 released" : "R3 high";
        q.push_back(lo);
        q.push_back(hi);
    endtask

    // runs n periods; the first nsw use setting 0, the rest setting 1 (R10)
    task automatic scen(input int d0, input int h0, input int l0, input int c0,
                        input int d1, input int h1, input int l1, input int c1,
                        input int nsw, input int n, input int s);
        int k;
        for (int p = 1; p <= n; p++) begin
            if (p <= nsw) push_period(d0, h0, l0, c0, s, p == n);
            else          push_period(d1, h1, l1, c1, s, p == n);
        end
        @(negedge clk);
        stretch_s = s;
        armed     = 1;
        div_in    = 8'(d0);
        cfg_word  = pack(h0, l0, c0);
        enable    = 1'b1;
        run       = 1'b1;
        k = 0;
        while (k < n) begin
            @(negedge clk);
            if (mid_low_stb) begin
                k++;
                if (k == nsw && nsw < n) begin
                    div_in   = 8'(d1);
                    cfg_word = pack(h1, l1, c1);
                end
                if (k == n) run = 1'b0;
            end
        end
        repeat (400) @(negedge clk);
        chk(scl_line == 1'b1, "R9 idle after stop", scl_line, 1);
        chk(q.size() == 1, "R9 all periods seen", q.size(), 1);
        armed = 0;
        stretch_s = 0;
        q.delete();
    endtask

    initial begin
        int cnt;
        repeat (5) @(negedge clk);
        chk(scl_drive_low == 1'b0, "R8 reset released", scl_drive_low, 0);
        chk(tick == 1'b0, "R1 reset no tick", tick, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R4: presets with spare ticks
        scen(7, 10, 11, 26, 7, 10, 11, 26, 3, 3, 0);
        scen(2, 5, 12, 24, 2, 5, 12, 24, 3, 3, 0);
        scen(1, 3, 9, 18, 1, 3, 9, 18, 3, 3, 0);
        // R3: cycle below high+low
        scen(3, 4, 5, 2, 3, 4, 5, 2, 2, 2, 0);
        // R5: stretching by the target
        scen(2, 3, 4, 0, 2, 3, 4, 0, 3, 3, 5);
        // R10: setting change mid-period
        scen(2, 5, 12, 24, 1, 3, 9, 18, 2, 4, 0);
        // R2/R3: all-zero setting clamps to one
        scen(0, 0, 0, 0, 0, 0, 0, 0, 3, 3, 0);

        // R1: tick rate over a window
        @(negedge clk);
        div_in = 8'd3; cfg_word = pack(4, 5, 2); enable = 1'b1; run = 1'b1;
        repeat (10) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (tick) cnt++;
        end
        chk(cnt == 20, "R1 tick rate", cnt, 20);
        run = 1'b0;
        repeat (300) @(negedge clk);

        // R8: disable in mid-low, then restart
        div_in = 8'd2; cfg_word = pack(3, 4, 0); enable = 1'b1; run = 1'b1;
        repeat (3) @(negedge clk);
        chk(scl_drive_low == 1'b1, "R9 started low", scl_drive_low, 1);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_drive_low == 1'b0, "R8 released on disable", scl_drive_low, 0);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick || mid_low_stb || mid_high_stb || scl_drive_low) cnt++;
        end
        chk(cnt == 0, "R8 silent while disabled", cnt, 0);
        scen(2, 3, 4, 0, 2, 3, 4, 0, 2, 2, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule